// File: doc/BRIEF.md
# Four-State Address Pin Decoder

This block works out how each of two address-select pins is strapped on the board. A pin can be tied low, tied high, tied to the serial data line, or tied to the serial clock line. It watches both pins next to the bus lines while a transfer is in progress. When the transfer ends, it turns the two results into the four variable bits of a 7-bit target address and into an 8-bit start-up pattern for a bank of eight outputs.

The "low" pin drives address bits 1..0 and output group 3..0. The "high" pin drives address bits 3..2 and output group 7..4. The two pins use different code tables.

Every transfer on the bus is used, whichever device it is meant for, so the strapping can change while the system runs. Before the first completed transfer, the block cannot tell a bus-tied pin from a high tie. It reports the pin's idle level instead and holds its valid flag low. All inputs are expected to be already synchronized to `clk`.

Top module: `addr_pin_decoder`

## Requirements
- R1: After reset, `valid_o` is 0, `addr_var_o` is 4'b1101 (both pins taken as high), and `dflt_o` is 8'hFF.
- R2: While `valid_o` is 0 and the bus is idle, each pin is classified from its present level only: low or high. Address bit 1 is then always 0 and address bit 3 is always 1.
- R3: The low pin drives `addr_var_o[1:0]` with these codes: low=00, high=01, tied to SCL=10, tied to SDA=11.
- R4: The high pin drives `addr_var_o[3:2]` with these codes: tied to SCL=00, tied to SDA=01, low=10, high=11.
- R5: A pin that changes during a transfer, and equals SDA at every sample where SDA and SCL differ, is classified as tied to SDA.
- R6: A pin that changes during a transfer, and equals SCL at every sample where SDA and SCL differ, is classified as tied to SCL.
- R7: `dflt_o[3:0]` comes from the low pin and `dflt_o[7:4]` from the high pin. A group is all zeros when its pin is classified low, and all ones in every other case.
- R8: A new classification takes effect only in the cycle after a STOP. Between STOPs, once `valid_o` is 1, `addr_var_o` does not change.
- R9: `valid_o` rises only in the cycle after the first STOP that ends a transfer. After that it stays 1.
- R10: Each transfer re-evaluates both pins, so a changed strapping shows up after the next STOP.
- R11: A pin that changed during a transfer but matched neither bus line keeps its previous classification.
- R12: START is SDA falling while SCL stays high, and STOP is SDA rising while SCL stays high. SDA changes made while SCL is low neither begin nor end a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_i | input | 1 | Synchronized serial data line |
| scl_i | input | 1 | Synchronized serial clock line |
| ad_lo_i | input | 1 | Synchronized pin selecting address bits 1..0 |
| ad_hi_i | input | 1 | Synchronized pin selecting address bits 3..2 |
| addr_var_o | output | 4 | Variable address bits 3..0 |
| dflt_o | output | 2*GROUP_W | Start-up output pattern, high group in the upper half |
| valid_o | output | 1 | At least one classification has been committed |

## Verification
The checker assumes the bus lines follow the normal two-wire protocol. Data changes only while SCL is low, except at START and STOP, and each pin either holds a fixed level or copies one bus line. Under those assumptions, the checker can require the address to stay steady between STOPs and both output groups to agree with the address codes.

The stimulus changes SDA, SCL and the pin straps only at falling clock edges. It changes strapping only while the bus is idle, so every transfer carries one consistent tie per pin. The only exception is a deliberately inconsistent pin, used to show that the previous classification is kept.

// File: rtl/apd_pkg.sv
package apd_pkg;

   typedef enum logic [1:0] {
      PC_LOW  = 2'd0,
      PC_HIGH = 2'd1,
      PC_SCL  = 2'd2,
      PC_SDA  = 2'd3
   } pin_class_e;

   typedef struct packed {
      logic seen0;
      logic seen1;
      logic sda_ok;
      logic scl_ok;
      logic disc;
   } track_t;

endpackage

// File: rtl/apd_bus_events.sv
module apd_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_i,
   input  logic scl_i,
   output logic start_o,
   output logic stop_o,
   output logic active_o
);
   logic sda_q, scl_q, active_q;

   // both edges qualified by SCL being high before and after
   assign start_o  = scl_q & scl_i & sda_q & ~sda_i;
   assign stop_o   = scl_q & scl_i & ~sda_q & sda_i;
   assign active_o = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_q    <= 1'b1;
         scl_q    <= 1'b1;
         active_q <= 1'b0;
      end else begin
         sda_q <= sda_i;
         scl_q <= scl_i;
         if (start_o)     active_q <= 1'b1;
         else if (stop_o) active_q <= 1'b0;
      end
   end
endmodule

// File: rtl/apd_pin_classifier.sv
module apd_pin_classifier
   import apd_pkg::*;
#(
   parameter pin_class_e RESET_CLASS = PC_HIGH
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic       sda_i,
   input  logic       scl_i,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic       active_i,
   input  logic       valid_i,
   output pin_class_e class_o
);
   track_t     trk_q, base, nxt;
   pin_class_e class_q, res;
   logic       res_ok, fresh;

   assign fresh = start_i & ~active_i;

   always_comb begin
      base = trk_q;
      if (fresh) begin
         base        = '0;
         base.sda_ok = 1'b1;
         base.scl_ok = 1'b1;
      end
      nxt       = base;
      nxt.seen0 = base.seen0 | ~pin_i;
      nxt.seen1 = base.seen1 | pin_i;
      if (sda_i != scl_i) begin
         nxt.disc = 1'b1;
         if (pin_i != sda_i) nxt.sda_ok = 1'b0;
         if (pin_i != scl_i) nxt.scl_ok = 1'b0;
      end
   end

   always_comb begin
      res    = pin_i ? PC_HIGH : PC_LOW;
      res_ok = 1'b1;
      if (nxt.seen0 && nxt.seen1) begin
         if (nxt.disc && nxt.sda_ok)      res = PC_SDA;
         else if (nxt.disc && nxt.scl_ok) res = PC_SCL;
         else                             res_ok = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trk_q   <= '0;
         class_q <= RESET_CLASS;
      end else begin
         if (start_i || active_i) trk_q <= nxt;
         if (active_i && stop_i) begin
            if (res_ok) class_q <= res;
         end else if (!valid_i && !active_i && !start_i) begin
            class_q <= pin_i ? PC_HIGH : PC_LOW;
         end
      end
   end

   assign class_o = class_q;
endmodule

// File: rtl/apd_class_encoder.sv
module apd_class_encoder
   import apd_pkg::*;
#(
   parameter bit HI_SIDE = 1'b0,
   parameter int GROUP_W = 4
) (
   input  pin_class_e         class_i,
   output logic [1:0]         code_o,
   output logic [GROUP_W-1:0] group_o
);
   generate
      if (HI_SIDE) begin : g_hi
         always_comb begin
            unique case (class_i)
               PC_SCL:  code_o = 2'b00;
               PC_SDA:  code_o = 2'b01;
               PC_LOW:  code_o = 2'b10;
               default: code_o = 2'b11;
            endcase
         end
      end else begin : g_lo
         always_comb begin
            unique case (class_i)
               PC_LOW:  code_o = 2'b00;
               PC_HIGH: code_o = 2'b01;
               PC_SCL:  code_o = 2'b10;
               default: code_o = 2'b11;
            endcase
         end
      end
   endgenerate

   assign group_o = (class_i == PC_LOW) ? '0 : '1;
endmodule

// File: rtl/addr_pin_decoder.sv
module addr_pin_decoder
   import apd_pkg::*;
#(
   parameter int GROUP_W = 4,
   localparam int DEF_W  = 2 * GROUP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_i,
   input  logic             scl_i,
   input  logic             ad_lo_i,
   input  logic             ad_hi_i,
   output logic [3:0]       addr_var_o,
   output logic [DEF_W-1:0] dflt_o,
   output logic             valid_o
);
   localparam int NPIN = 2;

   generate
      if (GROUP_W < 1) begin : g_bad_group
         $error("GROUP_W must be at least 1");
      end
   endgenerate

   logic               start_evt, stop_evt, active;
   logic               valid_q;
   logic [NPIN-1:0]    pins;
   pin_class_e         cls   [NPIN];
   logic [1:0]         codes [NPIN];
   logic [GROUP_W-1:0] grps  [NPIN];

   assign pins = {ad_hi_i, ad_lo_i};

   apd_bus_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_i    (sda_i),
      .scl_i    (scl_i),
      .start_o  (start_evt),
      .stop_o   (stop_evt),
      .active_o (active)
   );

   generate
      for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
         apd_pin_classifier #(.RESET_CLASS(PC_HIGH)) u_cls (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pins[gi]),
            .sda_i    (sda_i),
            .scl_i    (scl_i),
            .start_i  (start_evt),
            .stop_i   (stop_evt),
            .active_i (active),
            .valid_i  (valid_q),
            .class_o  (cls[gi])
         );
         apd_class_encoder #(.HI_SIDE(gi == 1), .GROUP_W(GROUP_W)) u_enc (
            .class_i (cls[gi]),
            .code_o  (codes[gi]),
            .group_o (grps[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 valid_q <= 1'b0;
      else if (active && stop_evt) valid_q <= 1'b1;
   end

   assign addr_var_o = {codes[1], codes[0]};
   assign dflt_o     = {grps[1], grps[0]};
   assign valid_o    = valid_q;
endmodule

// File: rtl/apd_checker.sv
module apd_checker #(
   parameter int GROUP_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [3:0]           addr_var_o,
   input logic [2*GROUP_W-1:0] dflt_o,
   input logic                 valid_o,
   input logic                 stop_evt,
   input logic                 active
);
   assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> valid_o);

   assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(stop_evt && active));

   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !(stop_evt && active)) |=> $stable(addr_var_o));

   assert_prevalid_levels_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (addr_var_o[1] == 1'b0 && addr_var_o[3] == 1'b1));

   assert_group_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dflt_o[GROUP_W-1:0] == '0) == (addr_var_o[1:0] == 2'b00));

   assert_group_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dflt_o[2*GROUP_W-1:GROUP_W] == '0) == (addr_var_o[3:2] == 2'b10));

   assert_group_uniform_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(dflt_o[GROUP_W-1:0]) == 0 || $countones(dflt_o[GROUP_W-1:0]) == GROUP_W));
endmodule

bind addr_pin_decoder apd_checker #(.GROUP_W(GROUP_W)) u_apd_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_var_o (addr_var_o),
   .dflt_o     (dflt_o),
   .valid_o    (valid_o),
   .stop_evt   (stop_evt),
   .active     (active)
);

// File: tb/addr_pin_decoder_bench.sv
`timescale 1ns/1ps
module addr_pin_decoder_bench;
   localparam int M_LOW = 0, M_HIGH = 1, M_SDA = 2, M_SCL = 3, M_NOISE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sda = 1'b1, scl = 1'b1, flip = 1'b0;
   int   mode_lo = M_HIGH, mode_hi = M_HIGH;
   logic ad_lo, ad_hi;
   logic [3:0] addr_var;
   logic [7:0] dflt;
   logic       valid;
   int errors = 0, checks = 0;
   bit done = 0;

   typedef struct {
      logic [3:0] a;
      logic [7:0] d;
      logic       v;
      string      tag;
   } exp_t;
   exp_t exp_q[$];
   event chk_ev;

   always #2.5 clk = ~clk;

   function automatic logic pin_val(int m, logic s, logic c, logic f);
      case (m)
         M_LOW:   return 1'b0;
         M_HIGH:  return 1'b1;
         M_SDA:   return s;
         M_SCL:   return c;
         default: return s ^ f;
      endcase
   endfunction

   assign ad_lo = pin_val(mode_lo, sda, scl, flip);
   assign ad_hi = pin_val(mode_hi, sda, scl, flip);

   addr_pin_decoder u_addr_pin_decoder (
      .clk(clk), .rst_n(rst_n), .sda_i(sda), .scl_i(scl),
      .ad_lo_i(ad_lo), .ad_hi_i(ad_hi),
      .addr_var_o(addr_var), .dflt_o(dflt), .valid_o(valid)
   );

   function automatic logic [1:0] lo_code(int m);
      case (m)
         M_LOW: return 2'b00; M_HIGH: return 2'b01;
         M_SCL: return 2'b10; default: return 2'b11;
      endcase
   endfunction

   function automatic logic [1:0] hi_code(int m);
      case (m)
         M_SCL: return 2'b00; M_SDA: return 2'b01;
         M_LOW: return 2'b10; default: return 2'b11;
      endcase
   endfunction

   function automatic logic [3:0] grp(int m);
      return (m == M_LOW) ? 4'h0 : 4'hF;
   endfunction

   task automatic push(input int ml, input int mh, input logic v, input string tag);
      exp_t e;
      e.a = {hi_code(mh), lo_code(ml)};
      e.d = {grp(mh), grp(ml)};
      e.v = v;
      e.tag = tag;
      exp_q.push_back(e);
      ->chk_ev;
      @(negedge clk);
   endtask

   task automatic cmp(input bit ok, input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            cmp(addr_var === e.a, e.tag, "addr", {4'h0, addr_var}, {4'h0, e.a});
            cmp(dflt === e.d, e.tag, "dflt", dflt, e.d);
            cmp(valid === e.v, e.tag, "valid", {7'h0, valid}, {7'h0, e.v});
         end
      end
   end

   task automatic step(input logic s, input logic c);
      @(negedge clk);
      sda = s;
      scl = c;
   endtask

   task automatic bus_start();
      step(1, 1); step(0, 1); step(0, 0);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic split);
      for (int i = 7; i >= 0; i--) begin
         if (i == 3) flip = split;
         step(b[i], 0); step(b[i], 1); step(b[i], 0);
      end
      step(0, 0); step(0, 1); step(0, 0);
   endtask

   task automatic bus_stop();
      step(0, 0); step(0, 1); step(1, 1);
      @(negedge clk);
   endtask

   task automatic transfer(input int ml, input int mh);
      mode_lo = ml;
      mode_hi = mh;
      bus_start();
      send_byte(8'hA5, 1'b0);
      bus_stop();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, pins high
      push(M_HIGH, M_HIGH, 1'b0, "R1");

      // R2: before any transfer, fixed-low pins follow their level
      mode_lo = M_LOW; mode_hi = M_LOW;
      repeat (2) @(negedge clk);
      push(M_LOW, M_LOW, 1'b0, "R2");

      // R2: bus-tied pins on an idle bus read as high
      mode_lo = M_SDA; mode_hi = M_SCL;
      repeat (2) @(negedge clk);
      push(M_HIGH, M_HIGH, 1'b0, "R2");

      // R12: SDA moves only while SCL is low, so no transfer occurs
      step(1, 0); step(0, 0); step(1, 0); step(1, 1);
      repeat (2) @(negedge clk);
      push(M_HIGH, M_HIGH, 1'b0, "R12");

      // R5 R6 R9: first transfer commits bus ties
      transfer(M_SDA, M_SCL);
      push(M_SDA, M_SCL, 1'b1, "R5_R6_R9");

      // R3 R4 R10: swapped bus ties after the next transfer
      transfer(M_SCL, M_SDA);
      push(M_SCL, M_SDA, 1'b1, "R3_R4_R10");

      // R7: mixed fixed ties
      transfer(M_LOW, M_HIGH);
      push(M_LOW, M_HIGH, 1'b1, "R7");
      transfer(M_HIGH, M_LOW);
      push(M_HIGH, M_LOW, 1'b1, "R7");

      // R8: new strapping is not visible before STOP
      mode_lo = M_SDA; mode_hi = M_SDA;
      repeat (3) @(negedge clk);
      push(M_HIGH, M_LOW, 1'b1, "R8");
      bus_start();
      send_byte(8'h3C, 1'b0);
      push(M_HIGH, M_LOW, 1'b1, "R8");
      bus_stop();
      push(M_SDA, M_SDA, 1'b1, "R8_R10");

      // R11: inconsistent low pin keeps SDA, high pin becomes low
      mode_lo = M_NOISE; mode_hi = M_LOW; flip = 1'b0;
      bus_start();
      send_byte(8'hA5, 1'b1);
      bus_stop();
      flip = 1'b0;
      push(M_SDA, M_LOW, 1'b1, "R11");

      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule